// File: doc/BRIEF.md
# Remote On/Off Debounce Sequencer

This controller turns a board-level remote on/off request into a command that enables or disables the main supply. The request arrives as an active-low logic level that is already synchronized to the clock. A free-running time-base pulse, `tick_i`, paces every delay. A fault-latched flag from elsewhere in the supervisor also feeds the block. The block accepts a change of the request, in either direction, only after the new level has held for a full debounce interval.

On an accepted turn-on, the block releases the supply disable and opens a blanking window. While the window is open, under-voltage checking stays masked. When the window closes, the block reports that those checks may run. On an accepted turn-off, the block first raises the power-good kill request. After a fixed drain delay it raises the supply disable. The same acceptance sends a one-cycle clear pulse to the fault latch, so the next turn-on starts clean.

All delays are given in nanoseconds and converted to tick counts. The default tick period is 10 µs, the debounce interval 38 ms, the drain delay 2.8 ms and the blanking window 75 ms.

Top module: `remote_onoff_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sup_dis_o`=1, `pg_kill_o`=1, `uv_arm_o`=0 and `flt_clr_o`=0. Reset treats the request as off.
- R2: A low level on `on_req_n_i` is accepted as "on" only after it has stayed low through DEB_TICKS consecutive ticks. `sup_dis_o` falls in the clock cycle after the cycle of acceptance.
- R3: If the request returns to the accepted level before the count completes, the count restarts from zero, and the accepted state and all outputs stay unchanged.
- R4: A high level is accepted as "off" under the same debounce rule as R2.
- R5: On an accepted "off", `pg_kill_o` rises first. `sup_dis_o` rises on the DRAIN_TICKS-th tick after that, which is 9 to 12 clocks later with a tick every 4 clocks and DRAIN_TICKS=3.
- R6: After an accepted "on", `uv_arm_o` stays 0 until the BLANK_TICKS-th tick. It then stays 1 until an "off" is accepted.
- R7: Each accepted "off" makes `flt_clr_o` high for exactly one cycle. That cycle is the cycle in which `pg_kill_o` rises.
- R8: While `fault_lat_i`=1, `sup_dis_o` and `pg_kill_o` are 1 from the next clock on. When the flag drops, both return to the values of the current phase.
- R9: An "off" accepted during the blanking window ends the window at once. `uv_arm_o` never rises, and the drain sequence of R5 runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base pulse, one clock wide |
| on_req_n_i | input | 1 | Synchronized request, low = on |
| fault_lat_i | input | 1 | Fault latched elsewhere |
| sup_dis_o | output | 1 | Supply disable request, high = converter off |
| pg_kill_o | output | 1 | Forces power-good low |
| uv_arm_o | output | 1 | Under-voltage checks may run |
| flt_clr_o | output | 1 | One-cycle fault-latch clear pulse |

## Verification
The request is driven with short low glitches and short high glitches, each shorter than the debounce interval. The outputs must then stay in their current state, which separates a restarting count from one that only pauses or accumulates. Clean held edges in both directions show whether the debounce is symmetric. The drain gap is timed from the rise of `pg_kill_o` to the rise of `sup_dis_o`, which exposes any swap of the two shutdown phases or a wrong delay length. A turn-off accepted inside the blanking window and a fault raised while running cover the two ways of leaving the normal phase order.

// File: rtl/remote_onoff_seq_pkg.sv
package remote_onoff_seq_pkg;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_BLANK = 2'd1,
        PH_RUN   = 2'd2,
        PH_DRAIN = 2'd3
    } seq_phase_e;

    typedef struct packed {
        seq_phase_e ph;
        logic       dis;
        logic       kill;
        logic       arm;
        logic       clr;
    } seq_regs_t;

    function automatic int unsigned ns_to_ticks(input longint unsigned ns,
                                                input longint unsigned tick_ns);
        longint unsigned t;
        t = ns / tick_ns;
        return (t == 0) ? 1 : int'(t);
    endfunction

endpackage

// File: rtl/remote_onoff_debounce.sv
module remote_onoff_debounce #(
    parameter int unsigned HOLD_TICKS = 3800,
    parameter int unsigned CW         = $clog2(HOLD_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic level_o
);
    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } deb_t;

    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d = deb_q;
        if (raw_i == deb_q.level) begin
            deb_d.cnt = '0;
        end else if (tick_i) begin
            if (deb_q.cnt == LAST) begin
                deb_d.level = raw_i;
                deb_d.cnt   = '0;
            end else begin
                deb_d.cnt = deb_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deb_q.level <= 1'b1;
            deb_q.cnt   <= '0;
        end else begin
            deb_q <= deb_d;
        end
    end

    assign level_o = deb_q.level;
endmodule

// File: rtl/remote_onoff_timer.sv
module remote_onoff_timer #(
    parameter int unsigned TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          done_o
);
    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign done_o = tmr_q.run && tick_i && (tmr_q.cnt == TW'(1));

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.run && tick_i) begin
            if (tmr_q.cnt == TW'(1)) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/remote_onoff_seq.sv
module remote_onoff_seq
    import remote_onoff_seq_pkg::*;
#(
    parameter longint unsigned TICK_NS  = 10_000,
    parameter longint unsigned DEB_NS   = 38_000_000,
    parameter longint unsigned DRAIN_NS = 2_800_000,
    parameter longint unsigned BLANK_NS = 75_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic on_req_n_i,
    input  logic fault_lat_i,
    output logic sup_dis_o,
    output logic pg_kill_o,
    output logic uv_arm_o,
    output logic flt_clr_o
);
    localparam int unsigned DEB_TICKS   = ns_to_ticks(DEB_NS, TICK_NS);
    localparam int unsigned DRAIN_TICKS = ns_to_ticks(DRAIN_NS, TICK_NS);
    localparam int unsigned BLANK_TICKS = ns_to_ticks(BLANK_NS, TICK_NS);
    localparam int unsigned MAX_TICKS   = (DRAIN_TICKS > BLANK_TICKS) ? DRAIN_TICKS : BLANK_TICKS;
    localparam int unsigned TW          = $clog2(MAX_TICKS + 1);
    localparam logic [TW-1:0] DRAIN_V   = TW'(DRAIN_TICKS);
    localparam logic [TW-1:0] BLANK_V   = TW'(BLANK_TICKS);

    logic          req_lvl;
    logic          tmr_done;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    seq_regs_t     seq_d, seq_q;

    remote_onoff_debounce #(.HOLD_TICKS(DEB_TICKS)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .raw_i   (on_req_n_i),
        .level_o (req_lvl)
    );

    remote_onoff_timer #(.TW(TW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.clr = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = BLANK_V;
        case (seq_q.ph)
            PH_OFF: begin
                if (!req_lvl) begin
                    seq_d.ph = PH_BLANK;
                    tmr_load = 1'b1;
                    tmr_val  = BLANK_V;
                end
            end
            PH_BLANK, PH_RUN: begin
                if (req_lvl) begin
                    seq_d.ph  = PH_DRAIN;
                    seq_d.clr = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = DRAIN_V;
                end else if (seq_q.ph == PH_BLANK && tmr_done) begin
                    seq_d.ph = PH_RUN;
                end
            end
            PH_DRAIN: begin
                if (tmr_done) begin
                    seq_d.ph = PH_OFF;
                end
            end
            default: seq_d.ph = PH_OFF;
        endcase
        seq_d.dis  = (seq_d.ph == PH_OFF) || fault_lat_i;
        seq_d.kill = (seq_d.ph == PH_OFF) || (seq_d.ph == PH_DRAIN) || fault_lat_i;
        seq_d.arm  = (seq_d.ph == PH_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph   <= PH_OFF;
            seq_q.dis  <= 1'b1;
            seq_q.kill <= 1'b1;
            seq_q.arm  <= 1'b0;
            seq_q.clr  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sup_dis_o = seq_q.dis;
    assign pg_kill_o = seq_q.kill;
    assign uv_arm_o  = seq_q.arm;
    assign flt_clr_o = seq_q.clr;
endmodule

// File: rtl/remote_onoff_seq_chk.sv
module remote_onoff_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic fault_lat_i,
    input logic sup_dis_o,
    input logic pg_kill_o,
    input logic uv_arm_o,
    input logic flt_clr_o
);
    // R5: a disable rise not caused by a fault needs power-good already killed
    assert_kill_before_dis_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_dis_o && !$past(sup_dis_o) && !$past(fault_lat_i)) |-> $past(pg_kill_o));

    // R7: the fault clear is a single-cycle pulse
    assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr_o |=> !flt_clr_o);

    // R7: the clear coincides with the start of the kill phase
    assert_clr_with_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr_o |-> pg_kill_o);

    // R8: a latched fault forces both shutdown outputs next cycle
    assert_fault_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_lat_i |=> (sup_dis_o && pg_kill_o));

    // R6: armed under-voltage checks imply a running supply unless faulted
    assert_arm_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_arm_o && !$past(fault_lat_i)) |-> (!sup_dis_o && !pg_kill_o));
endmodule

bind remote_onoff_seq remote_onoff_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_lat_i (fault_lat_i),
    .sup_dis_o   (sup_dis_o),
    .pg_kill_o   (pg_kill_o),
    .uv_arm_o    (uv_arm_o),
    .flt_clr_o   (flt_clr_o)
);

// File: tb/remote_onoff_seq_test.sv
`timescale 1ns/1ps
module remote_onoff_seq_test;
    localparam int DEB   = 5;
    localparam int DRAIN = 3;
    localparam int BLANK = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic req_n = 1'b1;
    logic fault = 1'b0;
    logic dis, kill, arm, clr;

    int total = 0;
    int bad = 0;
    string phase = "R1";
    bit done_flag = 0;

    // behavioural reference state
    int  m_stab, m_dc, m_st, m_tc, m_ldv, m_nst, m_old;
    bit  m_tr, m_done, m_load, m_clr;
    bit  e_dis, e_kill, e_arm, e_clr;

    remote_onoff_seq #(
        .TICK_NS(10), .DEB_NS(50), .DRAIN_NS(30), .BLANK_NS(80)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .on_req_n_i(req_n),
        .fault_lat_i(fault), .sup_dis_o(dis), .pg_kill_o(kill),
        .uv_arm_o(arm), .flt_clr_o(clr)
    );

    always #5 clk = ~clk;

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            tick = (c % 4 == 3);
            c++;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stab = 1; m_dc = 0; m_st = 0; m_tc = 0; m_tr = 0;
            e_dis = 1; e_kill = 1; e_arm = 0; e_clr = 0;
        end else begin
            m_old  = m_stab;
            m_done = m_tr && tick && (m_tc == 1);
            m_load = 0; m_ldv = 0; m_clr = 0; m_nst = m_st;
            if (req_n == m_stab) m_dc = 0;
            else if (tick) begin
                if (m_dc + 1 == DEB) begin m_stab = req_n; m_dc = 0; end
                else m_dc++;
            end
            if (m_st == 0) begin
                if (m_old == 0) begin m_nst = 1; m_load = 1; m_ldv = BLANK; end
            end else if (m_st == 1 || m_st == 2) begin
                if (m_old == 1) begin m_nst = 3; m_load = 1; m_ldv = DRAIN; m_clr = 1; end
                else if (m_st == 1 && m_done) m_nst = 2;
            end else begin
                if (m_done) m_nst = 0;
            end
            if (m_load) begin m_tc = m_ldv; m_tr = 1; end
            else if (m_tr && tick) begin
                if (m_tc == 1) m_tr = 0; else m_tc--;
            end
            m_st   = m_nst;
            e_dis  = (m_st == 0) || fault;
            e_kill = (m_st == 0) || (m_st == 3) || fault;
            e_arm  = (m_st == 2);
            e_clr  = m_clr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // every-clock comparison against the reference
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done_flag) begin
                chk({dis, kill, arm, clr} == {e_dis, e_kill, e_arm, e_clr}, phase,
                    {dis, kill, arm, clr}, {e_dis, e_kill, e_arm, e_clr});
            end
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p, d;
        bit seen_arm;
        wait_clk(3);
        phase = "R1";
        chk(dis && kill && !arm && !clr, "R1 in reset", {dis, kill, arm, clr}, 4'b1100);
        rst_n = 1'b1;
        wait_clk(1);
        chk(dis && kill && !arm && !clr, "R1 after reset", {dis, kill, arm, clr}, 4'b1100);

        // R3: low glitches shorter than the debounce interval
        phase = "R3";
        for (int k = 0; k < 3; k++) begin
            req_n = 1'b0; wait_clk(14);
            req_n = 1'b1; wait_clk(3);
        end
        wait_clk(20);
        chk(dis == 1'b1, "R3 on-glitch rejected", dis, 1);

        // R2: held low request
        phase = "R2";
        req_n = 1'b0;
        wait_clk(30);
        chk(dis == 1'b0, "R2 on accepted", dis, 0);

        // R6: blanking then arm
        phase = "R6";
        wait_clk(40);
        chk(arm == 1'b1, "R6 arm after window", arm, 1);

        // R3: high glitch while running
        phase = "R3";
        for (int k = 0; k < 2; k++) begin
            req_n = 1'b1; wait_clk(14);
            req_n = 1'b0; wait_clk(3);
        end
        wait_clk(10);
        chk(!dis && !kill && arm, "R3 off-glitch rejected", {dis, kill, arm}, 3'b001);

        // R4, R5, R7: held off request and drain timing
        phase = "R5";
        req_n = 1'b1;
        p = -1; d = -1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (kill && p < 0) begin
                p = i;
                chk(clr == 1'b1, "R7 clear with kill", clr, 1);
                chk(dis == 1'b0, "R5 kill before disable", dis, 0);
            end
            if (dis && d < 0) d = i;
        end
        chk(p >= 0, "R4 off accepted", p, 0);
        chk((d - p) >= 9 && (d - p) <= 12, "R5 drain gap", d - p, 10);

        // R8: fault while running
        phase = "R8";
        req_n = 1'b0;
        wait_clk(70);
        chk(arm == 1'b1, "R8 setup running", arm, 1);
        fault = 1'b1;
        wait_clk(1);
        chk(dis && kill, "R8 fault forces", {dis, kill}, 2'b11);
        fault = 1'b0;
        wait_clk(1);
        chk(!dis && !kill, "R8 fault release", {dis, kill}, 2'b00);

        // back to off
        phase = "R4";
        req_n = 1'b1;
        wait_clk(60);
        chk(dis && kill, "R4 off again", {dis, kill}, 2'b11);

        // R9: off accepted inside the blanking window
        phase = "R9";
        req_n = 1'b0;
        seen_arm = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (arm) seen_arm = 1;
            if (!dis && req_n == 1'b0) req_n = 1'b1;
        end
        chk(!seen_arm, "R9 arm never rose", seen_arm, 0);
        chk(dis && kill, "R9 ends off", {dis, kill}, 2'b11);

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule